// File: doc/BRIEF.md
# Quad DAC Register Interface

This block is the digital front end of a four-channel 12-bit digital-to-analog converter. Every channel has a first-rank input register that a host writes across one shared data port, and a second-rank DAC register that drives the converter. A host can fill the input registers one at a time, in 4-, 8- or 12-bit pieces. One update strobe then moves all four into the DAC registers on the same clock edge, so every analog output changes at once.

Each channel also holds a small mode register with two bits: the output range (unipolar or bipolar) and the gain (1 or 2). The host writes this register through the same port and can read it back. Readback returns either the selected slice of an input register or the selected mode register, with an output-enable that tells the pad when to drive the bus. A transparent setting makes one channel, or all four, follow their input registers on every clock. An asynchronous zero request forces each output to the code for zero volts in that channel's current range. The input registers are left untouched, and the outputs stay at zero until the next transfer.

Top module: `quad_dac_regif`

## Requirements
- R1: While `rst_n` is low, all input, DAC and mode registers clear. `dac_code`, `mode_bip`, `mode_gain2`, `data_out` and `data_oe` then read zero.
- R2: A write to a data register occurs when `cs`=1, `wr`=1, `rd`=0 and `tgt`=0. It goes to the input register of channel `ch_sel` and is shaped by `width_sel` (0 = 4-bit, 1 = 8-bit, 2 or 3 = 12-bit) and `slice_sel`. In 4-bit mode, slices 0, 1 and 2 load bits [3:0], [7:4] and [11:8] from `data_in[3:0]`, and slice 3 writes nothing. In 8-bit mode, slice 0 loads bits [7:0] from `data_in[7:0]`, slice 1 loads bits [11:8] from `data_in[3:0]`, and slices 2 and 3 write nothing. In 12-bit mode, the whole word loads from `data_in`. Bits outside the slice keep their values.
- R3: A write to an input register leaves `dac_code` unchanged unless a transfer (load or transparency) happens on the same edge.
- R4: `load`=1 at a clock edge copies every channel's input register (including any write on that edge) into its DAC register. `dac_code` shows the result after that edge.
- R5: With `xp_one`=1, the DAC register of channel `ch_sel` takes its input register's post-write value at every edge. With `xp_all`=1, all four channels do so.
- R6: A write with `tgt`=1 sets channel `ch_sel`'s mode. `data_in[0]` is the bipolar bit and `data_in[1]` the gain-of-2 bit. These appear on `mode_bip` and `mode_gain2`.
- R7: `data_oe` is 1 exactly when `cs`=1 and `rd`=1. `data_out` is then either the input-register slice selected by `width_sel`/`slice_sel`, right-aligned with the same slice map as R2, or `{gain2, bip}` in bits [1:0] when `tgt`=1. Unused slice codes read zero, and `data_out` is zero whenever `data_oe` is 0.
- R8: When `rd` and `wr` are both high, no register is written.
- R9: While `zero_n` is low, each channel's `dac_code` is 12'h000 when unipolar and 12'h800 when bipolar, following the current mode without waiting for a clock. Input registers still accept writes, and a load has no effect.
- R10: After `zero_n` returns high, a channel's output stays at its zero code until a load, or transparency on that channel, moves its input register into the DAC register.
- R11: With `cs`=0, `wr` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| zero_n | input | 1 | Asynchronous active-low force-to-zero-volts request |
| cs | input | 1 | Port select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read enable |
| tgt | input | 1 | Register target: 0 data, 1 mode |
| ch_sel | input | 2 | Channel index |
| width_sel | input | 2 | Access width: 0 nibble, 1 byte, 2/3 word |
| slice_sel | input | 2 | Slice within the word |
| data_in | input | 12 | Bus write data |
| load | input | 1 | Transfer all input registers to DAC registers |
| xp_one | input | 1 | Transparency for channel `ch_sel` |
| xp_all | input | 1 | Transparency for all channels |
| data_out | output | 12 | Readback data |
| data_oe | output | 1 | Tristate driver enable for readback |
| dac_code | output | 48 | Four 12-bit codes, channel 0 in bits [11:0] |
| mode_bip | output | 4 | Bipolar bit per channel |
| mode_gain2 | output | 4 | Gain-of-2 bit per channel |

## Verification
Directed writes cover every width and slice combination, including the unused slice codes. The resulting merges show whether unselected bits survive and whether the upper byte lands right-aligned. Two sequences separate the first rank from the second: writes with no transfer, then a load, then single-channel and all-channel transparency. Zero requests are issued on channels in mixed ranges, with a mode change and a load during the request. These show that the zero code tracks the mode, that input registers keep their data, and that the hold is released only by a transfer. A long random phase then mixes reads, writes, transfers and zero requests, and a behavioural model checks every cycle.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

   typedef enum logic [1:0] {
      QDR_NIB   = 2'd0,
      QDR_BYTE  = 2'd1,
      QDR_WORD  = 2'd2,
      QDR_WORD2 = 2'd3
   } qdr_width_e;

   typedef struct packed {
      logic gain2;
      logic bip;
   } qdr_mode_t;

endpackage

// File: rtl/qdr_slice_map.sv
module qdr_slice_map
   import qdr_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int NIB_W  = 4
) (
   input  logic [1:0]        width_sel,
   input  logic [1:0]        slice_sel,
   input  logic [CODE_W-1:0] wdata,
   output logic [CODE_W-1:0] wmask,
   output logic [CODE_W-1:0] wval
);
   localparam int BYTE_W = 2 * NIB_W;
   localparam int TOP_W  = CODE_W - BYTE_W;

   if (CODE_W != 3 * NIB_W) begin : g_bad_split
      $error("qdr_slice_map: CODE_W must be three nibbles");
   end

   logic [CODE_W-1:0] nib_mask;
   logic [CODE_W-1:0] nib_val;

   assign nib_mask = {{(CODE_W-NIB_W){1'b0}}, {NIB_W{1'b1}}};
   assign nib_val  = {{(CODE_W-NIB_W){1'b0}}, wdata[NIB_W-1:0]};

   always_comb begin
      wmask = '0;
      wval  = '0;
      case (qdr_width_e'(width_sel))
         QDR_NIB: begin
            if (slice_sel != 2'd3) begin
               wmask = nib_mask << (int'(slice_sel) * NIB_W);
               wval  = nib_val  << (int'(slice_sel) * NIB_W);
            end
         end
         QDR_BYTE: begin
            if (slice_sel == 2'd0) begin
               wmask = {{TOP_W{1'b0}}, {BYTE_W{1'b1}}};
               wval  = {{TOP_W{1'b0}}, wdata[BYTE_W-1:0]};
            end else if (slice_sel == 2'd1) begin
               wmask = {{TOP_W{1'b1}}, {BYTE_W{1'b0}}};
               wval  = {wdata[TOP_W-1:0], {BYTE_W{1'b0}}};
            end
         end
         default: begin
            wmask = '1;
            wval  = wdata;
         end
      endcase
   end

endmodule

// File: rtl/qdr_channel.sv
module qdr_channel
   import qdr_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero_n,
   input  logic              wr_data,
   input  logic              wr_mode,
   input  logic [CODE_W-1:0] wmask,
   input  logic [CODE_W-1:0] wval,
   input  qdr_mode_t         mode_wval,
   input  logic              load,
   input  logic              xp,
   output logic [CODE_W-1:0] in_q,
   output qdr_mode_t         mode_q,
   output logic [CODE_W-1:0] code_out
);
   localparam logic [CODE_W-1:0] ZERO_UNI = '0;
   localparam logic [CODE_W-1:0] ZERO_BIP = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] in_nxt;
   logic [CODE_W-1:0] dac_q;
   logic              hold_q;
   logic              xfer;

   assign in_nxt = wr_data ? ((in_q & ~wmask) | (wval & wmask)) : in_q;
   assign xfer   = load | xp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         mode_q <= '0;
      end else begin
         in_q <= in_nxt;
         if (wr_mode) begin
            mode_q <= mode_wval;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= '0;
      end else if (zero_n && xfer) begin
         dac_q <= in_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n or negedge zero_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (!zero_n) begin
         hold_q <= 1'b1;
      end else if (xfer) begin
         hold_q <= 1'b0;
      end
   end

   always_comb begin
      if (!zero_n || hold_q) begin
         code_out = mode_q.bip ? ZERO_BIP : ZERO_UNI;
      end else begin
         code_out = dac_q;
      end
   end

endmodule

// File: rtl/qdr_readback.sv
module qdr_readback
   import qdr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12,
   parameter int NIB_W  = 4,
   parameter int CH_W   = 2
) (
   input  logic                     oe,
   input  logic                     tgt,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic [1:0]               width_sel,
   input  logic [1:0]               slice_sel,
   input  logic [NUM_CH*CODE_W-1:0] in_flat,
   input  logic [NUM_CH-1:0]        bip_v,
   input  logic [NUM_CH-1:0]        g2_v,
   output logic [CODE_W-1:0]        rdata
);
   localparam int BYTE_W = 2 * NIB_W;
   localparam int TOP_W  = CODE_W - BYTE_W;

   logic [CODE_W-1:0] src;
   logic [CODE_W-1:0] dword;
   logic [CODE_W-1:0] mword;
   logic [CODE_W-1:0] nib_mask;

   assign nib_mask = {{(CODE_W-NIB_W){1'b0}}, {NIB_W{1'b1}}};
   assign src      = in_flat[int'(ch_sel)*CODE_W +: CODE_W];
   assign mword    = {{(CODE_W-2){1'b0}}, g2_v[ch_sel], bip_v[ch_sel]};

   always_comb begin
      dword = '0;
      case (qdr_width_e'(width_sel))
         QDR_NIB: begin
            if (slice_sel != 2'd3) begin
               dword = (src >> (int'(slice_sel) * NIB_W)) & nib_mask;
            end
         end
         QDR_BYTE: begin
            if (slice_sel == 2'd0) begin
               dword = {{TOP_W{1'b0}}, src[BYTE_W-1:0]};
            end else if (slice_sel == 2'd1) begin
               dword = {{BYTE_W{1'b0}}, src[CODE_W-1:BYTE_W]};
            end
         end
         default: dword = src;
      endcase
   end

   assign rdata = !oe ? '0 : (tgt ? mword : dword);

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
   import qdr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12,
   parameter int NIB_W  = 4,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     zero_n,
   input  logic                     cs,
   input  logic                     wr,
   input  logic                     rd,
   input  logic                     tgt,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic [1:0]               width_sel,
   input  logic [1:0]               slice_sel,
   input  logic [CODE_W-1:0]        data_in,
   input  logic                     load,
   input  logic                     xp_one,
   input  logic                     xp_all,
   output logic [CODE_W-1:0]        data_out,
   output logic                     data_oe,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        mode_bip,
   output logic [NUM_CH-1:0]        mode_gain2
);
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("quad_dac_regif: NUM_CH must be a power of two, at least 2");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("quad_dac_regif: CODE_W too small");
   end

   logic                     wr_en;
   logic [CODE_W-1:0]        wmask;
   logic [CODE_W-1:0]        wval;
   logic [NUM_CH*CODE_W-1:0] in_flat;
   qdr_mode_t                mode_wval;

   assign wr_en     = cs & wr & ~rd;
   assign data_oe   = cs & rd;
   assign mode_wval = '{gain2: data_in[1], bip: data_in[0]};

   qdr_slice_map #(
      .CODE_W (CODE_W),
      .NIB_W  (NIB_W)
   ) u_map (
      .width_sel (width_sel),
      .slice_sel (slice_sel),
      .wdata     (data_in),
      .wmask     (wmask),
      .wval      (wval)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic      hit;
      qdr_mode_t mq;

      assign hit = (ch_sel == CH_W'(i));

      qdr_channel #(
         .CODE_W (CODE_W)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .zero_n    (zero_n),
         .wr_data   (wr_en & ~tgt & hit),
         .wr_mode   (wr_en & tgt & hit),
         .wmask     (wmask),
         .wval      (wval),
         .mode_wval (mode_wval),
         .load      (load),
         .xp        (xp_all | (xp_one & hit)),
         .in_q      (in_flat[i*CODE_W +: CODE_W]),
         .mode_q    (mq),
         .code_out  (dac_code[i*CODE_W +: CODE_W])
      );

      assign mode_bip[i]   = mq.bip;
      assign mode_gain2[i] = mq.gain2;
   end

   qdr_readback #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W),
      .NIB_W  (NIB_W),
      .CH_W   (CH_W)
   ) u_rb (
      .oe        (data_oe),
      .tgt       (tgt),
      .ch_sel    (ch_sel),
      .width_sel (width_sel),
      .slice_sel (slice_sel),
      .in_flat   (in_flat),
      .bip_v     (mode_bip),
      .g2_v      (mode_gain2),
      .rdata     (data_out)
   );

endmodule

// File: rtl/qdr_checker.sv
module qdr_checker #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     zero_n,
   input logic                     cs,
   input logic                     wr,
   input logic                     rd,
   input logic                     tgt,
   input logic                     load,
   input logic                     xp_one,
   input logic                     xp_all,
   input logic [CODE_W-1:0]        data_out,
   input logic                     data_oe,
   input logic [NUM_CH*CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0]        mode_bip,
   input logic [NUM_CH*CODE_W-1:0] in_flat
);
   localparam logic [CODE_W-1:0] ZB = {1'b1, {(CODE_W-1){1'b0}}};

   // R1: registers come out of reset cleared
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dac_code == '0 && in_flat == '0));

   // R3: no transfer, no mode write and no zero activity leaves the outputs still
   a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_n && $past(zero_n) && $past(!load && !xp_one && !xp_all)
       && $past(!(cs && wr && !rd && tgt)))
      |-> dac_code == $past(dac_code));

   // R4: a load moves the post-write input registers to the outputs
   a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_n && $past(zero_n) && $past(load)) |-> dac_code == in_flat);

   // R7: bus is quiet when the driver is off
   a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> data_out == '0);

   // R8: a read cycle never writes
   a_r8_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd) |=> in_flat == $past(in_flat));

   // R11: deselected port never writes
   a_r11_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> in_flat == $past(in_flat));

   // R9: zero code follows each channel's range
   for (genvar i = 0; i < NUM_CH; i++) begin : g_zero
      a_r9_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
         !zero_n |-> dac_code[i*CODE_W +: CODE_W] == (mode_bip[i] ? ZB : '0));
   end

endmodule

bind quad_dac_regif qdr_checker #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .zero_n   (zero_n),
   .cs       (cs),
   .wr       (wr),
   .rd       (rd),
   .tgt      (tgt),
   .load     (load),
   .xp_one   (xp_one),
   .xp_all   (xp_all),
   .data_out (data_out),
   .data_oe  (data_oe),
   .dac_code (dac_code),
   .mode_bip (mode_bip),
   .in_flat  (in_flat)
);

// File: tb/quad_dac_regif_test.sv
module quad_dac_regif_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        zero_n = 1'b1;
   logic        cs = 1'b0, wr = 1'b0, rd = 1'b0, tgt = 1'b0;
   logic [1:0]  ch_sel = '0, width_sel = '0, slice_sel = '0;
   logic [11:0] data_in = '0;
   logic        load = 1'b0, xp_one = 1'b0, xp_all = 1'b0;
   logic [11:0] data_out;
   logic        data_oe;
   logic [47:0] dac_code;
   logic [3:0]  mode_bip, mode_gain2;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string phase   = "R1";

   // behavioural reference state
   logic [11:0] m_in  [4];
   logic [11:0] m_dac [4];
   bit          m_bip [4];
   bit          m_g2  [4];
   bit          m_hold[4];

   quad_dac_regif uut (
      .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .cs(cs), .wr(wr), .rd(rd),
      .tgt(tgt), .ch_sel(ch_sel), .width_sel(width_sel), .slice_sel(slice_sel),
      .data_in(data_in), .load(load), .xp_one(xp_one), .xp_all(xp_all),
      .data_out(data_out), .data_oe(data_oe), .dac_code(dac_code),
      .mode_bip(mode_bip), .mode_gain2(mode_gain2)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] merge(input logic [11:0] v);
      logic [11:0] r = v;
      case (width_sel)
         2'd0: if (slice_sel != 2'd3) r[4*slice_sel +: 4] = data_in[3:0];
         2'd1: begin
            if (slice_sel == 2'd0) r[7:0] = data_in[7:0];
            else if (slice_sel == 2'd1) r[11:8] = data_in[3:0];
         end
         default: r = data_in;
      endcase
      return r;
   endfunction

   function automatic logic [11:0] m_read();
      logic [11:0] v;
      if (!(cs && rd)) return 12'h000;
      if (tgt) return {10'b0, m_g2[ch_sel], m_bip[ch_sel]};
      v = m_in[ch_sel];
      case (width_sel)
         2'd0: return (slice_sel == 2'd3) ? 12'h000 : ((v >> (4*slice_sel)) & 12'h00F);
         2'd1: begin
            if (slice_sel == 2'd0) return {4'h0, v[7:0]};
            if (slice_sel == 2'd1) return {8'h00, v[11:8]};
            return 12'h000;
         end
         default: return v;
      endcase
   endfunction

   function automatic logic [47:0] m_code();
      logic [47:0] r;
      for (int i = 0; i < 4; i++)
         r[12*i +: 12] = (!zero_n || m_hold[i]) ? (m_bip[i] ? 12'h800 : 12'h000) : m_dac[i];
      return r;
   endfunction

   task automatic model_step();
      bit wok = cs && wr && !rd;
      for (int i = 0; i < 4; i++) begin
         logic [11:0] nxt = m_in[i];
         bit xp = xp_all || (xp_one && ch_sel == i[1:0]);
         if (!rst_n) begin
            m_in[i] = '0; m_dac[i] = '0; m_bip[i] = 0; m_g2[i] = 0; m_hold[i] = 0;
            continue;
         end
         if (wok && !tgt && ch_sel == i[1:0]) nxt = merge(m_in[i]);
         if (wok && tgt && ch_sel == i[1:0]) begin
            m_bip[i] = data_in[0];
            m_g2[i]  = data_in[1];
         end
         if (zero_n && (load || xp)) m_dac[i] = nxt;
         if (!zero_n) m_hold[i] = 1;
         else if (load || xp) m_hold[i] = 0;
         m_in[i] = nxt;
      end
   endtask

   task automatic compare_all();
      chk({phase, " dac_code"}, dac_code, m_code());
      chk({phase, " mode"}, {mode_gain2, mode_bip},
          {m_g2[3], m_g2[2], m_g2[1], m_g2[0], m_bip[3], m_bip[2], m_bip[1], m_bip[0]});
      chk({phase, " data_oe R7"}, data_oe, cs && rd);
      chk({phase, " data_out R7"}, data_out, m_read());
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cs = 0; wr = 0; rd = 0; tgt = 0; load = 0; xp_one = 0; xp_all = 0;
   endtask

   task automatic wr_data(input logic [1:0] ch, input logic [1:0] w,
                          input logic [1:0] s, input logic [11:0] d);
      cs = 1; wr = 1; tgt = 0; ch_sel = ch; width_sel = w; slice_sel = s; data_in = d;
      tick();
      idle();
   endtask

   task automatic wr_mode(input logic [1:0] ch, input logic [1:0] md);
      cs = 1; wr = 1; tgt = 1; ch_sel = ch; data_in = {10'b0, md};
      tick();
      idle();
   endtask

   task automatic rd_chk(input string req, input logic t, input logic [1:0] ch,
                         input logic [1:0] w, input logic [1:0] s, input logic [11:0] exp);
      cs = 1; rd = 1; tgt = t; ch_sel = ch; width_sel = w; slice_sel = s;
      #1;
      chk(req, {data_oe, data_out}, {1'b1, exp});
      tick();
      idle();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_in[i] = '0; m_dac[i] = '0; m_bip[i] = 0; m_g2[i] = 0; m_hold[i] = 0;
      end
      @(negedge clk);
      tick(); tick(); tick();
      chk("R1 reset dac_code", dac_code, 48'h0);
      chk("R1 reset mode", {mode_gain2, mode_bip}, 8'h00);
      chk("R1 reset bus", {data_oe, data_out}, 13'h0);
      rst_n = 1;
      tick();

      phase = "R2";
      wr_data(0, 2'd2, 2'd0, 12'hABC);
      wr_data(0, 2'd0, 2'd1, 12'h005);
      rd_chk("R2 nibble slice1 merge", 0, 0, 2'd2, 2'd0, 12'hA5C);
      wr_data(0, 2'd1, 2'd1, 12'h0F3);
      wr_data(0, 2'd0, 2'd3, 12'hFFF);
      wr_data(0, 2'd1, 2'd2, 12'hFFF);
      rd_chk("R2 byte high and unused slices", 0, 0, 2'd3, 2'd2, 12'h35C);
      phase = "R3";
      chk("R3 no transfer yet", dac_code, 48'h0);
      wr_data(1, 2'd2, 2'd0, 12'h123);
      wr_data(1, 2'd1, 2'd0, 12'h0AB);
      rd_chk("R2 byte low merge", 0, 1, 2'd2, 2'd0, 12'h1AB);
      wr_data(2, 2'd2, 2'd1, 12'hFFF);
      wr_data(3, 2'd3, 2'd0, 12'h800);

      phase = "R4";
      load = 1; tick(); idle();
      chk("R4 load all channels", dac_code, 48'h800FFF1AB35C);

      phase = "R6";
      wr_mode(1, 2'b01);
      wr_mode(2, 2'b11);
      chk("R6 mode bits", {mode_gain2, mode_bip}, 8'b0100_0110);

      phase = "R7";
      rd_chk("R7 nibble 0", 0, 0, 2'd0, 2'd0, 12'h00C);
      rd_chk("R7 nibble 2", 0, 0, 2'd0, 2'd2, 12'h003);
      rd_chk("R7 nibble 3 empty", 0, 0, 2'd0, 2'd3, 12'h000);
      rd_chk("R7 byte low", 0, 0, 2'd1, 2'd0, 12'h05C);
      rd_chk("R7 byte high", 0, 0, 2'd1, 2'd1, 12'h003);
      rd_chk("R7 mode ch2", 1, 2, 2'd0, 2'd0, 12'h003);
      rd_chk("R7 mode ch1", 1, 1, 2'd0, 2'd0, 12'h001);
      rd = 1; cs = 0; #1;
      chk("R7 no select no drive", {data_oe, data_out}, 13'h0);
      tick(); idle();

      phase = "R8";
      cs = 1; rd = 1; wr = 1; tgt = 0; ch_sel = 0; width_sel = 2'd2; data_in = 12'h000;
      tick(); idle();
      rd_chk("R8 rd+wr writes nothing", 0, 0, 2'd2, 2'd0, 12'h35C);

      phase = "R11";
      cs = 0; wr = 1; ch_sel = 0; width_sel = 2'd2; data_in = 12'h111;
      tick(); idle();
      rd_chk("R11 deselected write ignored", 0, 0, 2'd2, 2'd0, 12'h35C);

      phase = "R5";
      xp_one = 1; wr_data(3, 2'd2, 2'd0, 12'h0F0);
      chk("R5 single transparent", dac_code, 48'h0F0FFF1AB35C);
      wr_data(0, 2'd2, 2'd0, 12'h777);
      chk("R3 write without transfer", dac_code, 48'h0F0FFF1AB35C);
      xp_all = 1; wr_data(1, 2'd2, 2'd0, 12'h456);
      chk("R5 all transparent", dac_code, 48'h0F0FFF456777);

      phase = "R9";
      zero_n = 0; #1;
      chk("R9 zero code by range", dac_code, 48'h000800800000);
      wr_data(0, 2'd2, 2'd0, 12'h999);
      load = 1; tick(); idle();
      chk("R9 load during zero ignored", dac_code, 48'h000800800000);
      wr_mode(3, 2'b01);
      chk("R9 zero tracks mode", dac_code, 48'h800800800000);
      phase = "R10";
      zero_n = 1;
      tick();
      chk("R10 held after release", dac_code, 48'h800800800000);
      rd_chk("R9 input latch kept write", 0, 0, 2'd2, 2'd0, 12'h999);
      rd_chk("R9 input latch kept", 0, 2, 2'd2, 2'd0, 12'hFFF);
      xp_one = 1; ch_sel = 1; tick(); idle();
      chk("R10 transparency releases one", dac_code, 48'h800800456000);
      load = 1; tick(); idle();
      chk("R10 load releases all", dac_code, 48'h0F0FFF456999);

      phase = "R5 mixed";
      for (int n = 0; n < 600; n++) begin
         cs = $urandom_range(0, 3) != 0;
         rd = $urandom_range(0, 3) == 0;
         wr = $urandom_range(0, 1);
         tgt = $urandom_range(0, 5) == 0;
         ch_sel = 2'($urandom_range(0, 3));
         width_sel = 2'($urandom_range(0, 3));
         slice_sel = 2'($urandom_range(0, 3));
         data_in = 12'($urandom_range(0, 4095));
         load = $urandom_range(0, 7) == 0;
         xp_one = $urandom_range(0, 15) == 0;
         xp_all = $urandom_range(0, 31) == 0;
         zero_n = $urandom_range(0, 31) != 0;
         tick();
      end
      idle(); zero_n = 1;
      tick();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule